// File: doc/BRIEF.md
# Three-Phase Sine PWM Generator

This block drives a three-phase half-bridge inverter. It makes three pulse-width modulated phases whose duty cycles follow a sine wave. The phases are spaced a third of an electrical period apart. Each phase has a high-side gate and a complementary low-side gate. A programmable dead band sits between the two gates, so the pair is never on at the same time.

An up-counting carrier sets the switching period. The carrier is clocked by the input clock divided by `presc_div + 1`; a setting of 3 divides by four. The waveform step rate does not depend on the carrier. A 32-bit phase accumulator adds `step_inc` once per carrier period, and its top eight bits select one of 256 sine entries. Fractional increments therefore give fine speed resolution even at high electrical frequencies. Duty codes and the increment are captured only at the carrier overflow, so each switching period uses one consistent set of settings.

Top module: `spwm_gen`

## Requirements
- R1: While reset is asserted or `en` is low, all six gate outputs are held at their idle level, which is high.
- R2: The carrier counts 0..255 and wraps, giving a switching period of 256 counter ticks; one counter tick lasts `presc_div + 1` clock cycles.
- R3: With zero dead time, a high-side gate is high for exactly `duty × (presc_div + 1)` cycles per period (high while the count is below the duty code), and its low-side gate is the inverse.
- R4: The duty code for table entry i is within one code of 128·(1 + sin(2π·i/256)), limited to the range 0..255.
- R5: Phase A uses entry i, phase B uses entry (i + 85) mod 256 and phase C uses entry (i + 171) mod 256.
- R6: Once per carrier period the 32-bit accumulator adds the captured increment. Bits 31:24 form the table index of the next period, so increment 0x0180_0000 visits indices 0, 1, 3, 4, 6, 7, 9.
- R7: A new `step_inc` is captured only at a carrier overflow. A change made during period m first affects the index chosen for period m + 2.
- R8: Duty codes change only at a carrier overflow; inside a period they are constant.
- R9: After every change of a phase's raw PWM level, both of that phase's gates stay low for `dead_cnt` counter ticks before the new side turns on.
- R10: A high-side or low-side pulse that is shorter than the dead time never appears at the output.
- R11: While running, the high-side and low-side gates of one phase are never both high.
- R12: After `en` rises, the first period uses index 0, and it starts with both gates of every phase low for the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low forces idle outputs and restarts carrier and accumulator |
| presc_div | input | PRESC_W (8) | Carrier tick divider minus one |
| step_inc | input | ACC_W (32) | Phase accumulator increment per carrier period |
| dead_cnt | input | DT_W (8) | Dead time in counter ticks |
| gate_hi | output | 3 | High-side gates, bit 0 = phase A, 1 = B, 2 = C |
| gate_lo | output | 3 | Low-side gates, same bit order |

## Verification
On every cycle the assertions check the following: the carrier wraps after its top count; the duty codes, accumulator and captured increment hold still between overflows; the increment loads from the input at an overflow; both gates of a phase drop after any raw-level change when dead time is nonzero; and a gate pair is never on together. Only the bench's scenarios can show the numerical behaviour. These are the sine codes and the phase offsets, pulse widths scaled by the prescaler, index sequences for whole and fractional increments, the two-period latency of an increment change, the measured dead gap, pulse suppression below the dead time, and the idle levels.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  localparam int NPH = 3;

  // Sine code for entry i of a 2**w table, amplitude 2**(w-1) around mid-scale.
  // Half-wave rational approximation, rounded, clamped to the code range.
  function automatic int sine_code(input int i, input int w);
    longint ii;
    longint half;
    longint t;
    longint q;
    longint num;
    longint den;
    longint mag;
    longint val;
    ii   = longint'(i);
    half = longint'(1) << (w - 1);
    t    = (ii >= half) ? (ii - half) : ii;
    q    = t * (half - t);
    num  = longint'(16) * q * half;
    den  = longint'(5) * half * half - longint'(4) * q;
    mag  = (num + den / longint'(2)) / den;
    val  = (ii >= half) ? (half - mag) : (half + mag);
    if (val > longint'(2) * half - longint'(1)) val = longint'(2) * half - longint'(1);
    if (val < longint'(0)) val = longint'(0);
    return int'(val);
  endfunction

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick,
  output logic [CNT_W-1:0]   cnt,
  output logic               ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    tick   = run && (pcnt_q >= presc);
    pcnt_d = pcnt_q;
    cnt_d  = cnt_q;
    if (!run) begin
      pcnt_d = '0;
      cnt_d  = '0;
    end else if (tick) begin
      pcnt_d = '0;
      cnt_d  = cnt_q + 1'b1;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = tick && (cnt_q == CNT_MAX);

  // R2
  carrier_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ovf) |=> (cnt_q == '0));
  // R2
  carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && $past(run)) |=> $stable(cnt_q));

endmodule

// File: rtl/spwm_phase_acc.sv
module spwm_phase_acc #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ovf,
  input  logic [ACC_W-1:0] step_inc,
  output logic [IDX_W-1:0] idx_nxt
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] inc_q, inc_d;

  always_comb begin
    acc_d = acc_q;
    inc_d = inc_q;
    if (!run) begin
      acc_d = '0;
      inc_d = step_inc;
    end else if (ovf) begin
      acc_d = acc_q + inc_q;
      inc_d = step_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      inc_q <= '0;
    end else begin
      acc_q <= acc_d;
      inc_q <= inc_d;
    end
  end

  assign idx_nxt = acc_d[ACC_W-1 -: IDX_W];

  // R6
  acc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ovf) |=> $stable(acc_q));
  // R7
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ovf) |=> $stable(inc_q));
  // R7
  inc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ovf) |=> (inc_q == $past(step_inc)));

endmodule

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] code
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = IDX_W'(spwm_pkg::sine_code(g, IDX_W));
  end

  assign code = rom[idx];

endmodule

// File: rtl/spwm_duty.sv
module spwm_duty #(
  parameter int NPH   = 3,
  parameter int IDX_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      ovf,
  input  logic [IDX_W-1:0]          idx_nxt,
  output logic [NPH-1:0][IDX_W-1:0] cmp
);
  localparam int DEPTH = 1 << IDX_W;

  logic [NPH-1:0][IDX_W-1:0] code;
  logic [NPH-1:0][IDX_W-1:0] cmp_q, cmp_d;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    localparam int               OFF   = (p * DEPTH + NPH / 2) / NPH;
    localparam logic [IDX_W-1:0] OFF_V = IDX_W'(OFF);
    logic [IDX_W-1:0] ridx;
    assign ridx = idx_nxt + OFF_V;
    spwm_sine_rom #(.IDX_W(IDX_W)) u_rom (
      .idx  (ridx),
      .code (code[p])
    );
  end

  always_comb begin
    cmp_d = cmp_q;
    if (!run || ovf) cmp_d = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assign cmp = cmp_q;

  // R8
  duty_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ovf) |=> $stable(cmp_q));

endmodule

// File: rtl/spwm_deadband.sv
module spwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic            raw,
  input  logic [DT_W-1:0] dead,
  output logic            hi,
  output logic            lo
);
  logic            raw_q, raw_d;
  logic [DT_W-1:0] dcnt_q, dcnt_d;
  logic            settled;

  always_comb begin
    raw_d  = raw_q;
    dcnt_d = dcnt_q;
    if (!run) begin
      raw_d  = 1'b0;
      dcnt_d = dead;
    end else if (raw != raw_q) begin
      raw_d  = raw;
      dcnt_d = dead;
    end else if (tick && (dcnt_q != '0)) begin
      dcnt_d = dcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      raw_q  <= raw_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign settled = (dcnt_q == '0);
  assign hi      = !run || (raw_q && settled);
  assign lo      = !run || (!raw_q && settled);

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (raw_q != $past(raw_q)) && (dead != '0)) |-> (!hi && !lo));
  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !(hi && lo));

endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 8,
  parameter int ACC_W   = 32,
  parameter int DT_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [PRESC_W-1:0]       presc_div,
  input  logic [ACC_W-1:0]         step_inc,
  input  logic [DT_W-1:0]          dead_cnt,
  output logic [spwm_pkg::NPH-1:0] gate_hi,
  output logic [spwm_pkg::NPH-1:0] gate_lo
);
  localparam int NPH   = spwm_pkg::NPH;
  localparam int IDX_W = CNT_W;

  logic [1:0]                rst_sync_q;
  logic                      srst_n;
  logic                      run;
  logic                      tick;
  logic                      ovf;
  logic [CNT_W-1:0]          cnt;
  logic [IDX_W-1:0]          idx_nxt;
  logic [NPH-1:0][IDX_W-1:0] cmp;
  logic [NPH-1:0]            raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign srst_n = rst_sync_q[1];
  assign run    = en && srst_n;

  spwm_carrier #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_carrier (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (run),
    .presc (presc_div),
    .tick  (tick),
    .cnt   (cnt),
    .ovf   (ovf)
  );

  spwm_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (run),
    .ovf      (ovf),
    .step_inc (step_inc),
    .idx_nxt  (idx_nxt)
  );

  spwm_duty #(.NPH(NPH), .IDX_W(IDX_W)) u_duty (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (run),
    .ovf     (ovf),
    .idx_nxt (idx_nxt),
    .cmp     (cmp)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_out
    assign raw[p] = (cnt < cmp[p]);
    spwm_deadband #(.DT_W(DT_W)) u_db (
      .clk   (clk),
      .rst_n (srst_n),
      .run   (run),
      .tick  (tick),
      .raw   (raw[p]),
      .dead  (dead_cnt),
      .hi    (gate_hi[p]),
      .lo    (gate_lo[p])
    );
  end

endmodule

// File: tb/spwm_gen_tb.sv
module spwm_gen_tb;
  localparam real PI = 3.14159265358979;
  localparam int  WD = 150000;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [7:0]  presc_div;
  logic [31:0] step_inc;
  logic [7:0]  dead_cnt;
  logic [2:0]  gate_hi;
  logic [2:0]  gate_lo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  spwm_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .presc_div (presc_div),
    .step_inc  (step_inc),
    .dead_cnt  (dead_cnt),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= WD && !done) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  function automatic logic gate(input int sel);
    return (sel < 3) ? gate_hi[sel] : gate_lo[sel - 3];
  endfunction

  function automatic real sine_duty(input int idx);
    real e;
    e = 128.0 * (1.0 + $sin(2.0 * PI * idx / 256.0));
    if (e > 255.0) e = 255.0;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input real exp);
    real d;
    d = act - exp;
    chk((d <= 1.0) && (d >= -1.0), req, what, act, $rtoi(exp + 0.5));
  endtask

  // wait for a rising edge of the selected gate, return its high length in cycles
  task automatic measure_high(input int sel, output int w);
    @(negedge clk);
    while (gate(sel) != 1'b0) @(negedge clk);
    while (gate(sel) != 1'b1) @(negedge clk);
    w = 0;
    while (gate(sel) == 1'b1) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic measure_period(input int sel, output int w);
    @(negedge clk);
    while (gate(sel) != 1'b0) @(negedge clk);
    while (gate(sel) != 1'b1) @(negedge clk);
    w = 0;
    while (gate(sel) == 1'b1) begin w++; @(negedge clk); end
    while (gate(sel) == 1'b0) begin w++; @(negedge clk); end
  endtask

  // cycles from the fall of gate a until the rise of gate b
  task automatic measure_gap(input int a, input int b, output int n);
    @(negedge clk);
    while (gate(a) != 1'b1) @(negedge clk);
    while (gate(a) != 1'b0) @(negedge clk);
    n = 0;
    while (gate(b) == 1'b0) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_run(input int p, input logic [31:0] inc, input int dt);
    @(negedge clk);
    presc_div = 8'(p);
    step_inc  = inc;
    dead_cnt  = 8'(dt);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en = 1'b0;
    presc_div = 8'd3;
    step_inc = '0;
    dead_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: idle high during reset
    chk(gate_hi == 3'b111 && gate_lo == 3'b111, "R1", "reset idle", {gate_hi, gate_lo}, 6'h3f);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: idle high while disabled
    chk(gate_hi == 3'b111 && gate_lo == 3'b111, "R1", "disabled idle", {gate_hi, gate_lo}, 6'h3f);
  endtask

  task automatic t_offsets();
    int w;
    start_run(0, 32'd0, 0);
    measure_high(0, w);
    // R4 R5: phase A entry 0
    chk_near("R4", "phase A duty", w, sine_duty(0));
    measure_high(1, w);
    // R5: phase B entry 85
    chk_near("R5", "phase B duty", w, sine_duty(85));
    measure_high(2, w);
    // R5: phase C entry 171
    chk_near("R5", "phase C duty", w, sine_duty(171));
    measure_high(3, w);
    // R3: low side complement
    chk(w == 128, "R3", "phase A low width", w, 128);
    stop_run();
    // R1: back to idle after disable
    chk(gate_hi == 3'b111 && gate_lo == 3'b111, "R1", "idle after run", {gate_hi, gate_lo}, 6'h3f);
  endtask

  task automatic t_prescale();
    int w;
    start_run(3, 32'd0, 0);
    measure_high(0, w);
    // R3: width scales with prescaler
    chk(w == 512, "R3", "prescaled high width", w, 512);
    measure_period(0, w);
    // R2: period of 256 ticks of four cycles
    chk(w == 1024, "R2", "carrier period", w, 1024);
    stop_run();
  endtask

  task automatic t_sweep();
    int w;
    start_run(0, 32'h0500_0000, 0);
    for (int k = 1; k <= 4; k++) begin
      measure_high(0, w);
      // R6 R12: period k uses index 5k, first period was index 0
      chk_near("R6", "whole step sequence", w, sine_duty(5 * k));
    end
    stop_run();
  endtask

  task automatic t_frac();
    int w;
    start_run(0, 32'h0180_0000, 0);
    for (int k = 1; k <= 6; k++) begin
      measure_high(0, w);
      // R6: fractional increment, index floor(1.5k)
      chk_near("R6", "fractional step sequence", w, sine_duty((3 * k) / 2));
    end
    stop_run();
  endtask

  task automatic t_capture();
    int w;
    start_run(0, 32'h0500_0000, 0);
    for (int k = 1; k <= 4; k++) measure_high(0, w);
    step_inc = 32'h1400_0000;
    measure_high(0, w);
    // R7: next period still uses old increment
    chk_near("R7", "period after change", w, sine_duty(25));
    measure_high(0, w);
    // R7: second period after change uses new increment
    chk_near("R7", "two periods after change", w, sine_duty(45));
    stop_run();
  endtask

  task automatic t_dead();
    int  w;
    int  n;
    real c;
    start_run(0, 32'd0, 30);
    @(negedge clk);
    // R12: run starts with both gates low
    chk(gate_hi == 3'b000 && gate_lo == 3'b000, "R12", "start dead band", {gate_hi, gate_lo}, 0);
    measure_high(0, w);
    // R9: high side shortened by dead time
    chk(w == 98, "R9", "high width with dead time", w, 98);
    measure_gap(0, 3, n);
    // R9: gap between high fall and low rise
    chk(n == 30, "R9", "dead gap", n, 30);
    measure_high(3, w);
    // R9: low side shortened by dead time
    chk(w == 98, "R9", "low width with dead time", w, 98);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (gate_hi[2]) n++;
      // R11: pairs never both on (bench side)
      if ((gate_hi & gate_lo) != 3'b000) n += 1000;
    end
    // R10: phase C high pulse below dead time is suppressed
    chk(n == 0, "R10", "short pulse suppressed", n, 0);
    c = sine_duty(171);
    measure_high(5, w);
    // R10: phase C low side width
    chk_near("R10", "phase C low width", w, 256.0 - c - 30.0);
    stop_run();
  endtask

  initial begin
    t_reset();
    t_offsets();
    t_prescale();
    t_sweep();
    t_frac();
    t_capture();
    t_dead();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule